// File: doc/BRIEF.md
# Downward Byte Search Engine

The engine looks for one byte value in memory, walking from a start address toward lower addresses one byte per iteration. Each iteration reads a byte, subtracts it from the key to produce flags, then steps both the address and a 16-bit remaining-count down by one. The walk ends when the byte equals the key or when the count reaches zero. A starting count of zero therefore covers the full 65536-byte space.

Each iteration takes a fixed number of clock states. One clock equals one state. A repeating iteration lasts 21 states (4+4+3+5+5), and the final one lasts 16 (4+4+3+5). The memory read happens in the third machine cycle. Between repeating iterations the engine can hand control back when an interrupt is pending. It then stops with its address, count and flags on the outputs, and a new start using those values continues the walk from the same point.

Flags use a fixed bit layout, because the consumer decodes it: bit 7 sign, bit 6 zero, bit 4 half-borrow, bit 2 count-not-zero, bit 1 subtract, bit 0 carry. Bits 5 and 3 pass through from the incoming flag byte. A 32-bit state counter exposes the timing.

Top module: `bsd_engine`

## Requirements
- R1: After reset, `done`, `found`, `yielded`, `mem_rd` and `tstates` are all zero.
- R2: Each iteration computes `key - byte`. Flag bit 7 is bit 7 of the difference. Bit 6 is set when the byte equals the key. Bit 4 is set when the low nibble of the key is below the low nibble of the byte. Bit 1 is always set. Bits 5, 3 and 0 keep the values from `flags_in`.
- R3: Each iteration decrements both the address and the count by one, modulo 65536. The address wraps from 0x0000 to 0xFFFF.
- R4: A byte equal to the key ends the search with a one-cycle `done` pulse and with `found` high. The outputs show the address and count after that byte's decrement.
- R5: When the count reaches zero with no match, the search ends with `done` and with `found` low.
- R6: A start count of zero is treated as 65536. After k iterations the count is 65536-k.
- R7: Flag bit 2 is set exactly when the count after the decrement is nonzero.
- R8: `tstates` is cleared by an accepted start and counts every busy clock. At `done` it equals 21*(n-1)+16 for n iterations.
- R9: For each iteration, `mem_rd` is high for exactly one cycle, with `mem_addr` equal to the byte's address. The address stays stable in the next cycle, when the data is sampled. The number of reads equals the number of iterations.
- R10: If `irq_pending` is high at the last state of a repeating iteration, the engine pulses `yielded` instead of `done`. At that point `tstates` is 21*n. A new start from `addr_out`, `count_out` and `flags_out` ends exactly as an uninterrupted search would.
- R11: A `start` that arrives while a search is running has no effect on that search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock state per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when idle |
| start_addr | input | 16 | First address to read |
| start_count | input | 16 | Byte count; 0 means 65536 |
| key | input | 8 | Byte value searched for |
| flags_in | input | 8 | Incoming flag byte |
| irq_pending | input | 1 | Requests a yield at an iteration boundary |
| mem_addr | output | 16 | Memory read address |
| mem_rd | output | 1 | One-cycle read enable |
| mem_data | input | 8 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | One-cycle pulse when the search ends |
| found | output | 1 | Search ended on a match |
| yielded | output | 1 | One-cycle pulse when the engine yields |
| addr_out | output | 16 | Current or final address |
| count_out | output | 16 | Current or final count |
| flags_out | output | 8 | Updated flag byte |
| tstates | output | 32 | Clock states since the last accepted start |

## Verification
Random searches mix short counts, start addresses near zero and keys taken from memory or chosen at random. This separates an end on a match from an end on the count, and shows whether the address wraps. Directed cases cover a match on the first byte, a count of one, and a zero start count that matches after three bytes (count result 0xFFFD). A fixed byte and key produce the half-borrow and sign flags, with literal expected values. Searches that are yielded several times and then resumed must finish exactly as one continuous search, which shows that no iteration is lost or repeated. A stray start in the middle of a search must leave the result and the timing unchanged.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  typedef logic [7:0] flag_t;
  localparam int FB_S = 7;
  localparam int FB_Z = 6;
  localparam int FB_Y = 5;
  localparam int FB_H = 4;
  localparam int FB_X = 3;
  localparam int FB_P = 2;
  localparam int FB_N = 1;
  localparam int FB_C = 0;
endpackage

// File: rtl/bsd_pacer.sv
module bsd_pacer #(
  parameter int TKW = 5,
  parameter int TSW = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           clr_all,
  input  logic           clr_tick,
  input  logic           adv,
  output logic [TKW-1:0] tick,
  output logic [TSW-1:0] tstates
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tick    <= '0;
      tstates <= '0;
    end else begin
      if (clr_all || clr_tick) tick <= '0;
      else if (adv)            tick <= tick + 1'b1;
      if (clr_all)             tstates <= '0;
      else if (adv)            tstates <= tstates + 1'b1;
    end
  end
endmodule

// File: rtl/bsd_compare.sv
module bsd_compare import bsd_pkg::*; #(
  parameter int DW = 8,
  parameter int CW = 16
) (
  input  logic [DW-1:0] key,
  input  logic [DW-1:0] data,
  input  flag_t         fin,
  input  logic [CW-1:0] cnt_next,
  output flag_t         fout,
  output logic          hit
);
  logic [DW-1:0] diff;
  always_comb begin
    diff       = key - data;
    hit        = (key == data);
    fout       = fin;
    fout[FB_S] = diff[DW-1];
    fout[FB_Z] = hit;
    fout[FB_H] = (key[3:0] < data[3:0]);
    fout[FB_P] = (cnt_next != '0);
    fout[FB_N] = 1'b1;
  end
endmodule

// File: rtl/bsd_engine.sv
module bsd_engine import bsd_pkg::*; #(
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int DW    = 8,
  parameter int TSW   = 32,
  parameter int M1_ST = 4,
  parameter int M2_ST = 4,
  parameter int M3_ST = 3,
  parameter int M4_ST = 5,
  parameter int M5_ST = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [AW-1:0]  start_addr,
  input  logic [CW-1:0]  start_count,
  input  logic [DW-1:0]  key,
  input  logic [7:0]     flags_in,
  input  logic           irq_pending,
  output logic [AW-1:0]  mem_addr,
  output logic           mem_rd,
  input  logic [DW-1:0]  mem_data,
  output logic           done,
  output logic           found,
  output logic           yielded,
  output logic [AW-1:0]  addr_out,
  output logic [CW-1:0]  count_out,
  output logic [7:0]     flags_out,
  output logic [TSW-1:0] tstates
);
  localparam int LAST_ST  = M1_ST + M2_ST + M3_ST + M4_ST;
  localparam int ITER_ST  = LAST_ST + M5_ST;
  localparam int RD_TICK  = M1_ST + M2_ST;
  localparam int SMP_TICK = RD_TICK + 1;
  localparam int CMP_TICK = RD_TICK + M3_ST - 1;
  localparam int TKW      = $clog2(ITER_ST + 1);

  logic           busy, end_r, hit_r;
  logic [AW-1:0]  addr_r;
  logic [CW-1:0]  cnt_r, cnt_next;
  logic [DW-1:0]  key_r, data_r;
  flag_t          fin_r, flags_r, cmp_flags;
  logic           cmp_hit;
  logic [TKW-1:0] tick;
  logic           clr_all, clr_tick;

  assign cnt_next = cnt_r - 1'b1;
  assign clr_all  = start && !busy;
  assign clr_tick = busy && (tick == TKW'(ITER_ST - 1)) && !irq_pending;

  bsd_pacer #(.TKW(TKW), .TSW(TSW)) u_pacer (
    .clk(clk), .rst(rst), .clr_all(clr_all), .clr_tick(clr_tick),
    .adv(busy), .tick(tick), .tstates(tstates)
  );

  bsd_compare #(.DW(DW), .CW(CW)) u_cmp (
    .key(key_r), .data(data_r), .fin(fin_r), .cnt_next(cnt_next),
    .fout(cmp_flags), .hit(cmp_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      found   <= 1'b0;
      yielded <= 1'b0;
      mem_rd  <= 1'b0;
      end_r   <= 1'b0;
      hit_r   <= 1'b0;
      addr_r  <= '0;
      cnt_r   <= '0;
      key_r   <= '0;
      data_r  <= '0;
      fin_r   <= '0;
      flags_r <= '0;
    end else begin
      done    <= 1'b0;
      yielded <= 1'b0;
      mem_rd  <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          found   <= 1'b0;
          end_r   <= 1'b0;
          hit_r   <= 1'b0;
          addr_r  <= start_addr;
          cnt_r   <= start_count;
          key_r   <= key;
          fin_r   <= flags_in;
          flags_r <= flags_in;
        end
      end else begin
        if (tick == TKW'(RD_TICK - 1)) mem_rd <= 1'b1;
        if (tick == TKW'(SMP_TICK))    data_r <= mem_data;
        if (tick == TKW'(CMP_TICK)) begin
          flags_r <= cmp_flags;
          addr_r  <= addr_r - 1'b1;
          cnt_r   <= cnt_next;
          end_r   <= (cnt_next == '0) || cmp_hit;
          hit_r   <= cmp_hit;
        end
        if ((tick == TKW'(LAST_ST - 1)) && end_r) begin
          busy  <= 1'b0;
          done  <= 1'b1;
          found <= hit_r;
        end
        if ((tick == TKW'(ITER_ST - 1)) && irq_pending) begin
          busy    <= 1'b0;
          yielded <= 1'b1;
        end
      end
    end
  end

  assign mem_addr  = addr_r;
  assign addr_out  = addr_r;
  assign count_out = cnt_r;
  assign flags_out = flags_r;
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker import bsd_pkg::*; #(
  parameter int AW      = 16,
  parameter int CW      = 16,
  parameter int TSW     = 32,
  parameter int LAST_ST = 16,
  parameter int ITER_ST = 21
) (
  input logic           clk,
  input logic           rst,
  input logic           done,
  input logic           found,
  input logic           yielded,
  input logic           mem_rd,
  input logic [AW-1:0]  mem_addr,
  input logic [CW-1:0]  count_out,
  input logic [7:0]     flags_out,
  input logic [TSW-1:0] tstates
);
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_rd |=> !mem_rd); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) mem_rd |=> $stable(mem_addr)); // R9
  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst) !(done && yielded)); // R10
  AST_SUB_FLAG: assert property (@(posedge clk) disable iff (rst) (done || yielded) |-> flags_out[FB_N]); // R2
  AST_FOUND_ZERO: assert property (@(posedge clk) disable iff (rst) done |-> (found == flags_out[FB_Z])); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R4
  AST_PV_COUNT: assert property (@(posedge clk) disable iff (rst) (done || yielded) |-> (flags_out[FB_P] == (count_out != '0))); // R7
  AST_END_TIMING: assert property (@(posedge clk) disable iff (rst) done |-> ((tstates % ITER_ST) == LAST_ST)); // R8
  AST_YIELD_TIMING: assert property (@(posedge clk) disable iff (rst) yielded |-> ((tstates % ITER_ST) == 0)); // R10
endmodule

bind bsd_engine bsd_checker #(
  .AW(AW), .CW(CW), .TSW(TSW), .LAST_ST(LAST_ST), .ITER_ST(ITER_ST)
) u_bsd_checker (
  .clk(clk), .rst(rst), .done(done), .found(found), .yielded(yielded),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .count_out(count_out),
  .flags_out(flags_out), .tstates(tstates)
);

// File: tb/tb_bsd_engine.sv
module tb_bsd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] start_addr = '0, start_count = '0;
  logic [7:0]  key = '0, flags_in = '0;
  logic        irq_pending = 1'b0;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_data;
  logic        done, found, yielded;
  logic [15:0] addr_out, count_out;
  logic [7:0]  flags_out;
  logic [31:0] tstates;

  int checks = 0;
  int fails  = 0;
  int rd_cnt = 0;
  logic [15:0] last_rd_addr = '0;
  logic [7:0]  salt = 8'h3C;
  logic [15:0] ovr_addr = 16'h0000;
  logic [7:0]  ovr_data = 8'h00;
  bit          ovr_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bsd_engine dut (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .start_count(start_count), .key(key), .flags_in(flags_in),
    .irq_pending(irq_pending), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_data(mem_data), .done(done), .found(found), .yielded(yielded),
    .addr_out(addr_out), .count_out(count_out), .flags_out(flags_out),
    .tstates(tstates)
  );

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    if (ovr_on && a == ovr_addr) return ovr_data;
    return (a[7:0] * 8'd29) ^ ((a[15:8] * 8'd7) + salt);
  endfunction

  // synchronous read memory model
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_data     <= byte_at(mem_addr);
      rd_cnt       <= rd_cnt + 1;
      last_rd_addr <= mem_addr;
    end
  end

  function automatic void model(input logic [15:0] a0, c0, input logic [7:0] k, fl,
                                input bit irq, output logic [15:0] ao, co,
                                output logic [7:0] fo, output bit fnd, yld,
                                output int n);
    logic [15:0] a, c;
    logic [7:0] b, r;
    bit z;
    a = a0; c = c0; n = 0; fnd = 0; yld = 0; fo = fl;
    forever begin
      b = byte_at(a);
      r = k - b;
      z = (k == b);
      c = c - 1'b1;
      fo = {r[7], z, fl[5], (k[3:0] < b[3:0]), fl[3], (c != 0), 1'b1, fl[0]};
      a = a - 1'b1;
      n++;
      if (c == 0 || z) begin fnd = z; break; end
      if (irq) begin yld = 1; break; end
    end
    ao = a; co = c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [15:0] a, c, input logic [7:0] k, fl);
    @(negedge clk);
    start = 1'b1; start_addr = a; start_count = c; key = k; flags_in = fl;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit ok);
    ok = 0;
    for (int i = 0; i < WAIT_LIMIT; i++) begin
      if (done || yielded) begin ok = 1; break; end
      @(negedge clk);
    end
    if (!ok) begin
      checks++; fails++;
      $display("FAIL watchdog: actual no end expected done or yielded");
    end
  endtask

  // run one search and check every output against the model
  task automatic go(input logic [15:0] a, c, input logic [7:0] k, fl,
                    input bit irq, input bit poke, output bit yld_o);
    logic [15:0] ea, ec; logic [7:0] ef; bit efnd, eyld; int n, rd0; bit ok;
    model(a, c, k, fl, irq, ea, ec, ef, efnd, eyld, n);
    irq_pending = irq;
    rd0 = rd_cnt;
    pulse_start(a, c, k, fl);
    if (poke) begin
      repeat (25) @(negedge clk);
      start = 1'b1; start_addr = ~a; start_count = 16'd2; key = ~k; flags_in = ~fl;
      @(negedge clk);
      start = 1'b0;
    end
    wait_end(ok);
    yld_o = eyld;
    if (!ok) return;
    chk(eyld ? "R10 yielded" : "R4 done", {30'd0, done, yielded}, eyld ? 32'd1 : 32'd2);
    chk("R3 address", {16'd0, addr_out}, {16'd0, ea});
    chk("R3 count", {16'd0, count_out}, {16'd0, ec});
    chk("R2 flags", {24'd0, flags_out}, {24'd0, ef});
    if (!eyld) chk(efnd ? "R4 found" : "R5 not found", {31'd0, found}, {31'd0, efnd});
    chk(poke ? "R11 timing" : "R8 timing", tstates,
        eyld ? 32'(21 * n) : 32'(21 * (n - 1) + 16));
    @(negedge clk);
    chk("R9 read count", 32'(rd_cnt - rd0), 32'(n));
    chk("R9 last read address", {16'd0, last_rd_addr}, {16'd0, 16'(ea + 1'b1)});
    irq_pending = 1'b0;
  endtask

  // yield repeatedly, then resume to the end
  task automatic resume_case(input logic [15:0] a, c, input logic [7:0] k, fl, input int yields);
    logic [15:0] ea, ec; logic [7:0] ef; bit efnd, eyld, y; int n;
    model(a, c, k, fl, 1'b0, ea, ec, ef, efnd, eyld, n);
    go(a, c, k, fl, 1'b1, 1'b0, y);
    for (int i = 0; i < yields + 1 && y; i++)
      go(addr_out, count_out, k, flags_out, (i < yields), 1'b0, y);
    while (y) go(addr_out, count_out, k, flags_out, 1'b0, 1'b0, y);
    chk("R10 resumed address", {16'd0, addr_out}, {16'd0, ea});
    chk("R10 resumed count", {16'd0, count_out}, {16'd0, ec});
    chk("R10 resumed flags", {24'd0, flags_out}, {24'd0, ef});
    chk("R10 resumed found", {31'd0, found}, {31'd0, efnd});
  endtask

  function automatic logic [7:0] miss_key(input logic [15:0] a, c);
    logic [15:0] ea, ec; logic [7:0] ef, k; bit f, y; int n;
    k = 8'h00;
    for (int t = 0; t < 256; t++) begin
      model(a, c, k, 8'h00, 1'b0, ea, ec, ef, f, y, n);
      if (!f) break;
      k = k + 1'b1;
    end
    return k;
  endfunction

  initial begin
    bit y;
    logic [15:0] a, c; logic [7:0] k;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 done reset", {31'd0, done}, 0);
    chk("R1 found reset", {31'd0, found}, 0);
    chk("R1 yielded reset", {31'd0, yielded}, 0);
    chk("R1 read reset", {31'd0, mem_rd}, 0);
    chk("R1 tstates reset", tstates, 0);
    rst = 1'b0;
    @(negedge clk);

    // match on the very first byte
    go(16'h1234, 16'd5, byte_at(16'h1234), 8'h00, 1'b0, 1'b0, y);
    chk("R8 single iteration", tstates, 32'd16);
    // count of one, no match
    go(16'h0400, 16'd1, miss_key(16'h0400, 16'd1), 8'h01, 1'b0, 1'b0, y);
    chk("R5 count zero", {16'd0, count_out}, 0);
    chk("R7 pv clear", {31'd0, flags_out[2]}, 0);
    // zero start count = 65536, match at third byte
    ovr_on = 1'b1; ovr_addr = 16'h7FFE; ovr_data = 8'hA5;
    salt = 8'h3C;
    k = 8'hA5;
    if (byte_at(16'h8000) != k && byte_at(16'h7FFF) != k) begin
      go(16'h8000, 16'd0, k, 8'h00, 1'b0, 1'b0, y);
      chk("R6 wrapped count", {16'd0, count_out}, 32'hFFFD);
      chk("R7 pv set", {31'd0, flags_out[2]}, 1);
    end
    // address wrap below zero, no match
    ovr_on = 1'b0;
    go(16'h0001, 16'd4, miss_key(16'h0001, 16'd4), 8'h00, 1'b0, 1'b0, y);
    chk("R3 address wrap", {16'd0, addr_out}, 32'hFFFD);
    // half-borrow and pass-through bits: key 0x10, byte 0x01
    ovr_on = 1'b1; ovr_addr = 16'h2000; ovr_data = 8'h01;
    go(16'h2000, 16'd1, 8'h10, 8'h29, 1'b0, 1'b0, y);
    chk("R2 half borrow flags", {24'd0, flags_out}, 32'h3B);
    // sign and half-borrow: key 0x00, byte 0x01
    go(16'h2000, 16'd1, 8'h00, 8'h00, 1'b0, 1'b0, y);
    chk("R2 sign flags", {24'd0, flags_out}, 32'h92);
    ovr_on = 1'b0;
    // stray start while busy
    go(16'h5000, 16'd10, miss_key(16'h5000, 16'd10), 8'h01, 1'b0, 1'b1, y);
    // yield and resume
    resume_case(16'h3000, 16'd12, miss_key(16'h3000, 16'd12), 8'h09, 3);
    resume_case(16'h0003, 16'd9, byte_at(16'hFFFE), 8'h00, 2);

    // random searches
    for (int i = 0; i < 40; i++) begin
      a = 16'($urandom);
      if (i % 5 == 0) a = 16'($urandom_range(0, 6));
      c = 16'($urandom_range(1, 30));
      k = (i % 2 == 0) ? byte_at(16'(a - 16'($urandom_range(0, 25)))) : 8'($urandom);
      go(a, c, k, 8'($urandom), 1'b0, 1'b0, y);
    end
    for (int i = 0; i < 6; i++) begin
      a = 16'($urandom);
      c = 16'($urandom_range(4, 20));
      resume_case(a, c, 8'($urandom), 8'($urandom), int'($urandom_range(1, 3)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule